// File: doc/BRIEF.md
# Four-Channel Write-Multiplexer Configuration Registers

This block is the command-side register file of a multiplexer that merges four producer channels into one memory write path. Software writes 32-bit words at small word offsets. The block turns those writes into channel enables, a global enable, persistent channel resets, a per-channel status report selection, and a write port into a small start-address and length store. That store is kept outside this block.

The enable word and the mode word are both built from fields that carry their own set flag. A single write can therefore change one channel and leave every other channel as it was. When the global enable changes from off to on, the block also issues a pointer-reset request to all channels at once. System reset has the same effect. At all other times the pointer-reset request copies the persistent reset bits.

Every command is captured on the clock edge that samples the strobe, and it is applied on the next edge.

Top module: `dma_cfg_regs`

## Requirements
- R1: Offset 0 is the enable word. For channel c, bit 2c+1 is the set flag and bit 2c is the new value. The enable of a channel changes only when its set flag is 1, and other channels are not affected.
- R2: Bit 9 of the enable word is the set flag of the global enable and bit 8 is its value. It changes independently of the four channel pairs in the same word.
- R3: Offset 1 is the reset word. Bits [3:0] are the persistent channel resets, where 1 holds a channel in reset and 0 lets it run. They read all ones after system reset.
- R4: System reset clears the global enable and all channel enables, and sets every report selection to 0.
- R5: When the global enable goes from 0 to 1, the pointer-reset output is all ones for exactly one cycle. This is the cycle after the new enable value appears.
- R6: Outside the R5 case, the pointer-reset output equals the persistent reset bits delayed by one cycle. While system reset is active it is all ones.
- R7: Offset 2 is the mode word, with one 4-bit group per channel. Bits [1:0] of a group are the selection and bit 2 is the set flag. Bit 3 is ignored. A group whose set flag is 0 leaves its selection unchanged. The selections are: 0 = end-of-frame pointer as issued, 1 = end-of-frame pointer after acknowledge, 2 = current pointer as issued, 3 = current pointer after acknowledge.
- R8: A write to offsets 8..15 pulses the store write enable for one cycle. The store index is the offset minus 8, so indices 0..3 are start addresses and 4..7 are lengths. The store data is bits [26:0] of the command data.
- R9: Writes to offsets 3..7 change no output and produce no store write.
- R10: Every update becomes visible exactly one clock after the edge that samples the command strobe. Back-to-back strobes are each applied in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | Command write strobe |
| cmd_ofs | input | 4 | Command word offset |
| cmd_data | input | 32 | Command data |
| glob_en | output | 1 | Global enable |
| chan_en | output | 4 | Per-channel enables |
| chan_rst | output | 4 | Persistent per-channel resets |
| ptr_rst | output | 4 | Per-channel pointer-reset request |
| chan_mode | output | 8 | Report selection, two bits per channel |
| sl_we | output | 1 | Start/length store write enable |
| sl_idx | output | 3 | Start/length store index |
| sl_data | output | 27 | Start/length store data |

## Verification
The bench builds the block with its default of four channels and 27-bit address words. With these values the enable word has all five set/value pairs and the global pair sits at bits [9:8]. The mode word holds four full groups. The full offset range from 0 to 15 can be reached, including the unused gap between the mode word and the store offsets. A behavioural model checks every output on every cycle through unset pairs, mixed set flags, global enable edges, back-to-back strobes and store data whose upper bits must be dropped.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;

    localparam int NCH      = 4;
    localparam int SA_W     = 27;
    localparam int OFS_W    = 4;
    localparam int CMD_W    = 32;
    localparam int IDX_W    = 3;

    localparam logic [OFS_W-1:0] OFS_ENABLE = 4'd0;
    localparam logic [OFS_W-1:0] OFS_RESET  = 4'd1;
    localparam logic [OFS_W-1:0] OFS_MODE   = 4'd2;

    typedef enum logic [1:0] {
        RPT_EOF_ISSUED = 2'd0,
        RPT_EOF_ACKED  = 2'd1,
        RPT_CUR_ISSUED = 2'd2,
        RPT_CUR_ACKED  = 2'd3
    } rpt_sel_e;

    typedef struct packed {
        logic             en_wr;
        logic             rst_wr;
        logic             mode_wr;
        logic             sl_wr;
        logic [IDX_W-1:0] sl_idx;
        logic [SA_W-1:0]  data;
    } cfg_cmd_t;

    function automatic cfg_cmd_t decode_cmd(input logic stb,
                                            input logic [OFS_W-1:0] ofs,
                                            input logic [CMD_W-1:0] data);
        cfg_cmd_t c;
        c.en_wr   = stb && (ofs == OFS_ENABLE);
        c.rst_wr  = stb && (ofs == OFS_RESET);
        c.mode_wr = stb && (ofs == OFS_MODE);
        c.sl_wr   = stb && ofs[OFS_W-1];
        c.sl_idx  = ofs[IDX_W-1:0];
        c.data    = data[SA_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/dma_cmd_stage.sv
module dma_cmd_stage
    import dma_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic [OFS_W-1:0] ofs,
    input  logic [CMD_W-1:0] data,
    output cfg_cmd_t         cmd_q
);
    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= decode_cmd(stb, ofs, data);
    end

    // at most one destination decoded per command
    AST_ONE_DEST: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_q.en_wr, cmd_q.rst_wr, cmd_q.mode_wr, cmd_q.sl_wr})); // R9
endmodule

// File: rtl/dma_pair_bank.sv
module dma_pair_bank #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic [2*N-1:0] pairs,
    output logic [N-1:0]   val
);
    for (genvar i = 0; i < N; i++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst)                       val[i] <= 1'b0;
            else if (wr && pairs[2*i+1])   val[i] <= pairs[2*i];
        end

        AST_PAIR_UNSET_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr && pairs[2*i+1]) |=> $stable(val[i])); // R1
    end
endmodule

// File: rtl/dma_mode_bank.sv
module dma_mode_bank
    import dma_cfg_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic [4*N-1:0] word,
    output logic [2*N-1:0] mode
);
    for (genvar c = 0; c < N; c++) begin : g_grp
        rpt_sel_e sel_q;
        always_ff @(posedge clk) begin
            if (rst)                      sel_q <= RPT_EOF_ISSUED;
            else if (wr && word[4*c+2])   sel_q <= rpt_sel_e'(word[4*c +: 2]);
        end
        assign mode[2*c +: 2] = sel_q;

        AST_MODE_UNSET_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr && word[4*c+2]) |=> $stable(mode[2*c +: 2])); // R7
    end
endmodule

// File: rtl/dma_ptr_reset.sv
module dma_ptr_reset #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         glob_en,
    input  logic [N-1:0] chan_rst,
    output logic [N-1:0] ptr_rst
);
    logic glob_en_d;
    logic rise;

    assign rise = glob_en && !glob_en_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en_d <= 1'b0;
            ptr_rst   <= '1;
        end else begin
            glob_en_d <= glob_en;
            ptr_rst   <= rise ? '1 : chan_rst;
        end
    end

    AST_PTR_ALL_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(glob_en) |=> (ptr_rst == {N{1'b1}})); // R5
    AST_PTR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !$rose(glob_en) |=> (ptr_rst == $past(chan_rst))); // R6
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_cfg_pkg::*;
#(
    parameter int N_CH = NCH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_stb,
    input  logic [OFS_W-1:0]  cmd_ofs,
    input  logic [CMD_W-1:0]  cmd_data,
    output logic              glob_en,
    output logic [N_CH-1:0]   chan_en,
    output logic [N_CH-1:0]   chan_rst,
    output logic [N_CH-1:0]   ptr_rst,
    output logic [2*N_CH-1:0] chan_mode,
    output logic              sl_we,
    output logic [IDX_W-1:0]  sl_idx,
    output logic [SA_W-1:0]   sl_data
);
    localparam int GLB_LSB = 2 * N_CH;

    cfg_cmd_t cmd_q;

    dma_cmd_stage i_stage (
        .clk(clk), .rst(rst), .stb(cmd_stb), .ofs(cmd_ofs), .data(cmd_data), .cmd_q(cmd_q)
    );

    dma_pair_bank #(.N(N_CH)) i_chan_en (
        .clk(clk), .rst(rst), .wr(cmd_q.en_wr),
        .pairs(cmd_q.data[2*N_CH-1:0]), .val(chan_en)
    );

    dma_pair_bank #(.N(1)) i_glob_en (
        .clk(clk), .rst(rst), .wr(cmd_q.en_wr),
        .pairs(cmd_q.data[GLB_LSB +: 2]), .val(glob_en)
    );

    dma_mode_bank #(.N(N_CH)) i_mode (
        .clk(clk), .rst(rst), .wr(cmd_q.mode_wr),
        .word(cmd_q.data[4*N_CH-1:0]), .mode(chan_mode)
    );

    dma_ptr_reset #(.N(N_CH)) i_ptr (
        .clk(clk), .rst(rst), .glob_en(glob_en), .chan_rst(chan_rst), .ptr_rst(ptr_rst)
    );

    always_ff @(posedge clk) begin
        if (rst)               chan_rst <= '1;
        else if (cmd_q.rst_wr) chan_rst <= cmd_q.data[N_CH-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sl_we   <= 1'b0;
            sl_idx  <= '0;
            sl_data <= '0;
        end else begin
            sl_we <= cmd_q.sl_wr;
            if (cmd_q.sl_wr) begin
                sl_idx  <= cmd_q.sl_idx;
                sl_data <= cmd_q.data;
            end
        end
    end

    AST_RST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd_q.rst_wr |=> $stable(chan_rst)); // R3
    AST_SL_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_stb) |=> !sl_we); // R8
    AST_SL_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_ofs[OFS_W-1]) |=> ##1 sl_we); // R10
endmodule

// File: tb/test_dma_cfg_regs.sv
module test_dma_cfg_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_stb = 1'b0;
    logic [3:0]  cmd_ofs = '0;
    logic [31:0] cmd_data = '0;
    logic        glob_en;
    logic [3:0]  chan_en, chan_rst, ptr_rst;
    logic [7:0]  chan_mode;
    logic        sl_we;
    logic [2:0]  sl_idx;
    logic [26:0] sl_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dma_cfg_regs i_dma_cfg_regs (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_ofs(cmd_ofs), .cmd_data(cmd_data),
        .glob_en(glob_en), .chan_en(chan_en), .chan_rst(chan_rst), .ptr_rst(ptr_rst),
        .chan_mode(chan_mode), .sl_we(sl_we), .sl_idx(sl_idx), .sl_data(sl_data)
    );

    // behavioural model state
    bit        m_glob, m_gprev, m_we;
    bit [3:0]  m_en, m_crst, m_ptr;
    bit [7:0]  m_mode;
    bit [2:0]  m_idx;
    bit [26:0] m_sdata;
    bit        p_stb;
    bit [3:0]  p_ofs;
    bit [31:0] p_data;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_glob = 0; m_gprev = 0; m_en = 0; m_crst = 4'hf; m_ptr = 4'hf;
            m_mode = 0; m_we = 0; m_idx = 0; m_sdata = 0; p_stb = 0;
        end else begin
            m_ptr   = (m_glob && !m_gprev) ? 4'hf : m_crst;
            m_gprev = m_glob;
            m_we    = 0;
            if (p_stb) begin
                if (p_ofs == 0) begin
                    for (int c = 0; c < 4; c++) if (p_data[2*c+1]) m_en[c] = p_data[2*c];
                    if (p_data[9]) m_glob = p_data[8];
                end else if (p_ofs == 1) begin
                    m_crst = p_data[3:0];
                end else if (p_ofs == 2) begin
                    for (int c = 0; c < 4; c++)
                        if (p_data[4*c+2]) m_mode[2*c +: 2] = p_data[4*c +: 2];
                end else if (p_ofs >= 8) begin
                    m_we = 1; m_idx = 3'(p_ofs - 8); m_sdata = p_data[26:0];
                end
            end
            p_stb = cmd_stb; p_ofs = cmd_ofs; p_data = cmd_data;
        end
        #2;
        chk("R1/R10 chan_en", 32'(chan_en), 32'(m_en));
        chk("R2 glob_en", 32'(glob_en), 32'(m_glob));
        chk("R3 chan_rst", 32'(chan_rst), 32'(m_crst));
        chk("R5/R6 ptr_rst", 32'(ptr_rst), 32'(m_ptr));
        chk("R7 chan_mode", 32'(chan_mode), 32'(m_mode));
        chk("R8/R9 sl_we", 32'(sl_we), 32'(m_we));
        if (m_we) begin
            chk("R8 sl_idx", 32'(sl_idx), 32'(m_idx));
            chk("R8 sl_data", 32'(sl_data), 32'(m_sdata));
        end
    end

    task automatic wr(input logic [3:0] ofs, input logic [31:0] data);
        @(negedge clk);
        cmd_stb = 1'b1; cmd_ofs = ofs; cmd_data = data;
        @(negedge clk);
        cmd_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R4 R3 R6: state during and right after reset
        chk("R4 reset glob_en", 32'(glob_en), 0);
        chk("R4 reset chan_en", 32'(chan_en), 0);
        chk("R4 reset chan_mode", 32'(chan_mode), 0);
        chk("R3 reset chan_rst", 32'(chan_rst), 32'hf);
        chk("R6 reset ptr_rst", 32'(ptr_rst), 32'hf);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1: single-channel, multi-channel, clear, value without set flag
        wr(4'd0, 32'h0C);
        chk("R1 ch1 on", 32'(chan_en), 32'h2);
        wr(4'd0, 32'h33);
        wr(4'd0, 32'h02);
        wr(4'd0, 32'h55);
        chk("R1 unset pairs ignored", 32'(chan_en), 32'h6);
        // R10: timing of one write observed directly
        @(negedge clk);
        cmd_stb = 1'b1; cmd_ofs = 4'd0; cmd_data = 32'h300;
        @(negedge clk);
        cmd_stb = 1'b0;
        chk("R10 not yet applied", 32'(glob_en), 0);
        @(negedge clk);
        chk("R10 applied", 32'(glob_en), 1);
        chk("R5 pointer reset before pulse", 32'(ptr_rst), 32'hf);
        repeat (3) @(negedge clk);
        wr(4'd0, 32'h300);              // already on: no new pulse (R5)
        wr(4'd1, 32'h5);                // R3, R6
        wr(4'd1, 32'h0);
        chk("R6 follows resets", 32'(ptr_rst), 0);
        wr(4'd2, 32'h7);                // R7 ch0 sel 3
        wr(4'd2, 32'h500);              // ch2 sel 1
        wr(4'd2, 32'hBBBB);             // no set flags, bit3 set: ignored
        chk("R7 unset groups", 32'(chan_mode), 32'h13);
        wr(4'd2, 32'h4567);
        chk("R7 all groups", 32'(chan_mode), 32'h1B);
        for (int o = 8; o < 16; o++) wr(4'(o), 32'hF000_0000 | 32'(o * 32'h0111_1111));
        for (int o = 3; o < 8; o++) wr(4'(o), 32'hFFFF_FFFF);  // R9
        chk("R9 gap offsets", 32'({glob_en, chan_en, chan_rst, chan_mode}), 32'({1'b1, 4'h6, 4'h0, 8'h1B}));
        wr(4'd0, 32'h200);              // global off
        wr(4'd0, 32'h3FF);              // global on plus all channels on
        // R10 back-to-back strobes
        @(negedge clk);
        cmd_stb = 1'b1; cmd_ofs = 4'd1; cmd_data = 32'hA;
        @(negedge clk);
        cmd_ofs = 4'd9; cmd_data = 32'h0123_4567;
        @(negedge clk);
        cmd_ofs = 4'd0; cmd_data = 32'h2;
        @(negedge clk);
        cmd_stb = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 back-to-back", 32'({chan_rst, chan_en}), 32'({4'hA, 4'hE}));
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 second reset", 32'({glob_en, chan_en, chan_mode}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule